// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block owns one base register that places a 4-Kbyte window of on-chip peripheral registers at any 4-Kbyte-aligned page of a 32-bit address space. Every bus access is classified in the same cycle into exactly one of four destinations: the peripheral window, on-chip SRAM/cache, a chip-select region, or the external bus. The SRAM and chip-select decoders supply their own hit signals. The block resolves overlaps by fixed priority, and it can push window hits of selected access classes out to the external bus.

The base register is written by privileged software through a control-register port, where it is selected by register number 0xC0F. A debug port can both read and write it. Only the enable bit has a reset value, so the window cannot claim any access until software has written the register. A write-protect bit turns writes that land in the window into a single-cycle access-error pulse.

The access address arrives as its page number, meaning bits [31:12], because the byte offset inside a page plays no part in the decode.

Top module: `pwd_decoder`

## Requirements
- R1: Reset clears the enable bit (bit 0). While the enable bit is 0, `sel_periph`, `nocache` and `acc_err` stay low for every access.
- R2: `dbg_rdata` returns the register in this layout: page base in [31:12], write-protect in 8, alternate-master mask in 6, CPU-space mask in 5, supervisor-code mask in 4, supervisor-data mask in 3, user-code mask in 2, user-data mask in 1, enable in 0. Bits [11:9] and 7 read as 0.
- R3: A control-port write updates the register on the next clock edge only when `ctl_wr_en` is high, `ctl_regnum` is 0xC0F and `ctl_super` is 1. A control-port write with any other register number, or with `ctl_super` at 0, leaves the register unchanged.
- R4: A debug write updates the register on the next edge. When a debug write and a control write occur in the same cycle, the debug data is stored.
- R5: With the enable bit at 1, an access whose `acc_page` equals the base field hits the window. An unmasked hit asserts `sel_periph`, and an access to any other page does not hit.
- R6: Each access is mapped to one mask bit, checked in this order. `acc_alt` uses bit 6. Otherwise `acc_cpu` uses bit 5. Otherwise supervisor code uses bit 4, supervisor data uses bit 3, user code uses bit 2, and user data uses bit 1. A mask bit of 1 masks that access class.
- R7: A window hit whose class is masked selects `sel_ext`, even when `sram_hit` or `cs_hit` is also high.
- R8: When the window does not hit, the priority is `sram_hit`, then `cs_hit`, then the external bus.
- R9: `nocache` is high exactly when an access hits the window unmasked.
- R10: When write-protect is 1, an unmasked window hit by a write raises `acc_err` for the cycle of that access and asserts no select. A read of the same page still selects `sel_periph`.
- R11: Every valid access raises exactly one select, except the protected write of R10, which raises none. With `acc_valid` low, no select and no `acc_err` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr_en | input | 1 | Control-register write strobe |
| ctl_regnum | input | 12 | Control-register number of the write |
| ctl_super | input | 1 | Writer is in supervisor mode |
| ctl_wdata | input | 32 | Control-register write data |
| dbg_wr_en | input | 1 | Debug write strobe |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read-back of the base register |
| acc_valid | input | 1 | Access present this cycle |
| acc_page | input | 20 | Access address bits [31:12] |
| acc_write | input | 1 | Access is a write |
| acc_super | input | 1 | Access is in supervisor mode |
| acc_code | input | 1 | Access is an instruction fetch |
| acc_cpu | input | 1 | CPU-space / interrupt-acknowledge cycle |
| acc_alt | input | 1 | Access from an alternate bus master |
| sram_hit | input | 1 | SRAM/cache decoder hit |
| cs_hit | input | 1 | Chip-select decoder hit |
| sel_periph | output | 1 | Route to the peripheral window |
| sel_sram | output | 1 | Route to SRAM/cache |
| sel_cs | output | 1 | Route to a chip-select region |
| sel_ext | output | 1 | Route to the external bus |
| nocache | output | 1 | Access must not be cached |
| acc_err | output | 1 | Write to a protected window |

## Verification
The assertions check these properties on every cycle:
- the one-hot select rule;
- the silence of all outputs for idle cycles;
- the link between `nocache` and a peripheral select;
- the quiet window while the register is disabled;
- the store of debug writes;
- the rejection of user-mode control writes.

Only the bench scenarios can show the rest:
- the exact mask bit chosen for each access class;
- the masked-hit override of SRAM and chip-select hits;
- the read-versus-write split under write-protect;
- register-number decoding.

These depend on particular register contents that the bench sets up and then reads back through the debug port.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 12;
  localparam int PAGE_W = ADDR_W - OFS_W;

  // bit positions of the base register
  localparam int B_VALID = 0;
  localparam int B_UD    = 1;
  localparam int B_UC    = 2;
  localparam int B_SD    = 3;
  localparam int B_SC    = 4;
  localparam int B_CPU   = 5;
  localparam int B_ALT   = 6;
  localparam int B_WP    = 8;

  localparam logic [ADDR_W-1:0] KEEP_MASK = 32'hFFFF_F17F;

  typedef enum logic [1:0] {T_PERIPH, T_SRAM, T_CS, T_EXT} target_e;

  typedef struct packed {
    logic alt;
    logic cpu;
    logic super_m;
    logic code;
  } acc_class_t;

  // window page compare
  function automatic logic page_match(logic [PAGE_W-1:0] base,
                                      logic [PAGE_W-1:0] page);
    return base == page;
  endfunction

  // pick the mask bit governing an access class
  function automatic logic class_masked(logic [6:0] m, acc_class_t c);
    if (c.alt)          return m[B_ALT];
    else if (c.cpu)     return m[B_CPU];
    else if (c.super_m) return c.code ? m[B_SC] : m[B_SD];
    else                return c.code ? m[B_UC] : m[B_UD];
  endfunction
endpackage

// File: rtl/pwd_base_reg.sv
module pwd_base_reg
  import pwd_pkg::*;
#(
  parameter logic [11:0] CTL_REGNUM = 12'hC0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [11:0]       ctl_regnum,
  input  logic              ctl_super,
  input  logic [ADDR_W-1:0] ctl_wdata,
  input  logic              dbg_wr_en,
  input  logic [ADDR_W-1:0] dbg_wdata,
  output logic [ADDR_W-1:0] reg_q
);
  logic              ctl_take;
  logic              upd;
  logic [ADDR_W-1:0] nxt;
  logic              valid_q;
  logic [ADDR_W-1:1] rest_q;

  assign ctl_take = ctl_wr_en && ctl_super && (ctl_regnum == CTL_REGNUM);
  assign upd      = dbg_wr_en || ctl_take;
  assign nxt      = (dbg_wr_en ? dbg_wdata : ctl_wdata) & KEEP_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   valid_q <= 1'b0;
    else if (upd) valid_q <= nxt[B_VALID];
  end

  // no reset on the other fields: undefined until written
  always_ff @(posedge clk) begin
    if (upd) rest_q <= nxt[ADDR_W-1:1];
  end

  assign reg_q = {rest_q, valid_q};
endmodule

// File: rtl/pwd_window_hit.sv
module pwd_window_hit
  import pwd_pkg::*;
(
  input  logic [ADDR_W-1:0] reg_q,
  input  logic              acc_valid,
  input  logic [PAGE_W-1:0] acc_page,
  input  acc_class_t        acc_cls,
  output logic              win_hit,
  output logic              space_masked
);
  assign win_hit      = acc_valid && reg_q[B_VALID] &&
                        page_match(reg_q[ADDR_W-1:OFS_W], acc_page);
  assign space_masked = class_masked(reg_q[6:0], acc_cls);
endmodule

// File: rtl/pwd_target_arb.sv
module pwd_target_arb
  import pwd_pkg::*;
(
  input  logic acc_valid,
  input  logic acc_write,
  input  logic wp,
  input  logic win_hit,
  input  logic space_masked,
  input  logic sram_hit,
  input  logic cs_hit,
  output logic [3:0] sel,
  output logic win_claim,
  output logic wp_block
);
  target_e tgt;

  assign win_claim = win_hit && !space_masked;
  assign wp_block  = win_claim && acc_write && wp;

  always_comb begin
    if (win_hit && space_masked) tgt = T_EXT;
    else if (win_claim)          tgt = T_PERIPH;
    else if (sram_hit)           tgt = T_SRAM;
    else if (cs_hit)             tgt = T_CS;
    else                         tgt = T_EXT;
  end

  always_comb begin
    sel = '0;
    if (acc_valid && !wp_block) sel[tgt] = 1'b1;
  end
endmodule

// File: rtl/pwd_decoder.sv
module pwd_decoder
  import pwd_pkg::*;
#(
  parameter logic [11:0] CTL_REGNUM = 12'hC0F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr_en,
  input  logic [11:0] ctl_regnum,
  input  logic        ctl_super,
  input  logic [31:0] ctl_wdata,
  input  logic        dbg_wr_en,
  input  logic [31:0] dbg_wdata,
  output logic [31:0] dbg_rdata,
  input  logic        acc_valid,
  input  logic [19:0] acc_page,
  input  logic        acc_write,
  input  logic        acc_super,
  input  logic        acc_code,
  input  logic        acc_cpu,
  input  logic        acc_alt,
  input  logic        sram_hit,
  input  logic        cs_hit,
  output logic        sel_periph,
  output logic        sel_sram,
  output logic        sel_cs,
  output logic        sel_ext,
  output logic        nocache,
  output logic        acc_err
);
  logic [ADDR_W-1:0] reg_q;
  logic              win_hit;
  logic              space_masked;
  logic              win_claim;
  logic              wp_block;
  logic [3:0]        sel;
  acc_class_t        cls;

  assign cls = '{alt: acc_alt, cpu: acc_cpu, super_m: acc_super, code: acc_code};

  pwd_base_reg #(.CTL_REGNUM(CTL_REGNUM)) u_reg (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_regnum(ctl_regnum), .ctl_super(ctl_super),
    .ctl_wdata(ctl_wdata), .dbg_wr_en(dbg_wr_en), .dbg_wdata(dbg_wdata),
    .reg_q(reg_q)
  );

  pwd_window_hit u_hit (
    .reg_q(reg_q), .acc_valid(acc_valid), .acc_page(acc_page),
    .acc_cls(cls), .win_hit(win_hit), .space_masked(space_masked)
  );

  pwd_target_arb u_arb (
    .acc_valid(acc_valid), .acc_write(acc_write), .wp(reg_q[B_WP]),
    .win_hit(win_hit), .space_masked(space_masked),
    .sram_hit(sram_hit), .cs_hit(cs_hit),
    .sel(sel), .win_claim(win_claim), .wp_block(wp_block)
  );

  assign dbg_rdata  = reg_q;
  assign sel_periph = sel[T_PERIPH];
  assign sel_sram   = sel[T_SRAM];
  assign sel_cs     = sel[T_CS];
  assign sel_ext    = sel[T_EXT];
  assign nocache    = win_claim;
  assign acc_err    = wp_block;
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr_en,
  input logic        ctl_super,
  input logic        dbg_wr_en,
  input logic [31:0] dbg_wdata,
  input logic [31:0] dbg_rdata,
  input logic        acc_valid,
  input logic        sel_periph,
  input logic        sel_sram,
  input logic        sel_cs,
  input logic        sel_ext,
  input logic        nocache,
  input logic        acc_err,
  input logic        win_hit
);
  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_rdata[0] |-> (!sel_periph && !nocache && !acc_err && !win_hit));
  // R11
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_err) |-> ($countones({sel_periph, sel_sram, sel_cs, sel_ext}) == 1));
  // R11
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> ({sel_periph, sel_sram, sel_cs, sel_ext, acc_err} == 5'b0));
  // R10
  err_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> ({sel_periph, sel_sram, sel_cs, sel_ext} == 4'b0));
  // R9
  periph_nocache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_periph |-> nocache);
  // R4
  dbg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr_en |=> (dbg_rdata == ($past(dbg_wdata) & 32'hFFFF_F17F)));
  // R3
  user_ctl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && !ctl_super && !dbg_wr_en) |=> $stable(dbg_rdata));
endmodule

bind pwd_decoder pwd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_super(ctl_super),
  .dbg_wr_en(dbg_wr_en), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
  .acc_valid(acc_valid), .sel_periph(sel_periph), .sel_sram(sel_sram),
  .sel_cs(sel_cs), .sel_ext(sel_ext), .nocache(nocache), .acc_err(acc_err),
  .win_hit(win_hit)
);

// File: tb/sim_pwd_decoder.sv
module sim_pwd_decoder;
  logic clk = 0;
  logic rst_n = 0;
  logic ctl_wr_en = 0, ctl_super = 0, dbg_wr_en = 0;
  logic [11:0] ctl_regnum = 0;
  logic [31:0] ctl_wdata = 0, dbg_wdata = 0, dbg_rdata;
  logic acc_valid = 0, acc_write = 0, acc_super = 0, acc_code = 0, acc_cpu = 0, acc_alt = 0;
  logic [19:0] acc_page = 0;
  logic sram_hit = 0, cs_hit = 0;
  logic sel_periph, sel_sram, sel_cs, sel_ext, nocache, acc_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwd_decoder u0 (.*);

  // output vector: {periph, sram, cs, ext, nocache, err}
  localparam logic [5:0] O_PER = 6'b100010, O_SRAM = 6'b010000, O_CS = 6'b001000,
                         O_EXT = 6'b000100, O_ERR = 6'b000001, O_NONE = 6'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic dbg_wr(logic [31:0] d);
    @(negedge clk); dbg_wr_en = 1; dbg_wdata = d;
    @(negedge clk); dbg_wr_en = 0;
  endtask

  task automatic ctl_wr(logic [11:0] n, logic sup, logic [31:0] d);
    @(negedge clk); ctl_wr_en = 1; ctl_regnum = n; ctl_super = sup; ctl_wdata = d;
    @(negedge clk); ctl_wr_en = 0;
  endtask

  // apply an access and return the outputs
  task automatic acc(input logic [19:0] pg, input logic wr, sup, code, cpu, alt, sh, ch,
                     output logic [5:0] o);
    @(negedge clk);
    acc_valid = 1; acc_page = pg; acc_write = wr; acc_super = sup; acc_code = code;
    acc_cpu = cpu; acc_alt = alt; sram_hit = sh; cs_hit = ch;
    #2 o = {sel_periph, sel_sram, sel_cs, sel_ext, nocache, acc_err};
    @(negedge clk); acc_valid = 0; sram_hit = 0; cs_hit = 0;
  endtask

  task automatic t_reset();
    logic [5:0] o;
    chk("R1 enable cleared", {31'b0, dbg_rdata[0]}, 32'h0);
    acc(20'h00000, 0, 1, 0, 0, 0, 0, 0, o);
    chk("R1 no window before write", {26'b0, o}, {26'b0, O_EXT});
    #1 chk("R11 idle no select", {26'b0, sel_periph, sel_sram, sel_cs, sel_ext, nocache, acc_err}, 0);
  endtask

  task automatic t_regs();
    dbg_wr(32'hFFFF_FFFF);
    chk("R2 reserved read zero", dbg_rdata, 32'hFFFF_F17F);
    ctl_wr(12'hC0F, 0, 32'h1234_5001);
    chk("R3 user write ignored", dbg_rdata, 32'hFFFF_F17F);
    ctl_wr(12'hC0E, 1, 32'h1234_5001);
    chk("R3 other regnum ignored", dbg_rdata, 32'hFFFF_F17F);
    ctl_wr(12'hC0F, 1, 32'h1234_5001);
    chk("R3 supervisor write taken", dbg_rdata, 32'h1234_5001);
    @(negedge clk); dbg_wr_en = 1; dbg_wdata = 32'hAAAA_A001;
    ctl_wr_en = 1; ctl_regnum = 12'hC0F; ctl_super = 1; ctl_wdata = 32'h5555_5001;
    @(negedge clk); dbg_wr_en = 0; ctl_wr_en = 0;
    chk("R4 debug wins", dbg_rdata, 32'hAAAA_A001);
  endtask

  task automatic t_window();
    logic [5:0] o;
    dbg_wr(32'h4000_0001);
    acc(20'h40000, 0, 1, 0, 0, 0, 1, 1, o);
    chk("R5 R9 window hit beats sram/cs", {26'b0, o}, {26'b0, O_PER});
    acc(20'h40001, 0, 1, 0, 0, 0, 0, 0, o);
    chk("R5 neighbour page misses", {26'b0, o}, {26'b0, O_EXT});
    acc(20'h40001, 0, 1, 0, 0, 0, 1, 1, o);
    chk("R8 sram over cs", {26'b0, o}, {26'b0, O_SRAM});
    acc(20'h40001, 0, 1, 0, 0, 0, 0, 1, o);
    chk("R8 cs over ext", {26'b0, o}, {26'b0, O_CS});
  endtask

  task automatic t_masks();
    logic [5:0] o;
    // each row: mask bit, then the class that bit governs
    for (int b = 1; b <= 6; b++) begin
      logic sup, code, cpu, alt;
      alt = (b == 6); cpu = (b == 5);
      sup = (b == 3 || b == 4); code = (b == 2 || b == 4);
      dbg_wr(32'h4000_0001 | (32'h1 << b));
      acc(20'h40000, 0, sup, code, cpu, alt, 1, 1, o);
      chk($sformatf("R6 R7 mask bit %0d routes ext", b), {26'b0, o}, {26'b0, O_EXT});
      // a class governed by another bit is still served
      acc(20'h40000, 0, (b == 1 || b == 2), 1'b0, 0, 0, 0, 0, o);
      chk($sformatf("R6 other class with bit %0d", b), {26'b0, o}, {26'b0, O_PER});
    end
    // alternate master takes precedence over its own supervisor class
    dbg_wr(32'h4000_0001 | 32'h10);
    acc(20'h40000, 0, 1, 1, 0, 1, 0, 0, o);
    chk("R6 alt ignores supervisor-code mask", {26'b0, o}, {26'b0, O_PER});
  endtask

  task automatic t_wp();
    logic [5:0] o;
    dbg_wr(32'h4000_0101);
    acc(20'h40000, 1, 1, 0, 0, 0, 0, 0, o);
    chk("R10 protected write errors", {26'b0, o}, {26'b0, O_ERR | 6'b000010});
    #1 chk("R10 error lasts one cycle", {31'b0, acc_err}, 0);
    acc(20'h40000, 0, 1, 0, 0, 0, 0, 0, o);
    chk("R10 protected read served", {26'b0, o}, {26'b0, O_PER});
    acc(20'h40002, 1, 1, 0, 0, 0, 0, 0, o);
    chk("R10 write outside window ok", {26'b0, o}, {26'b0, O_EXT});
  endtask

  task automatic t_disable();
    logic [5:0] o;
    ctl_wr(12'hC0F, 1, 32'h4000_0000);
    acc(20'h40000, 0, 1, 0, 0, 0, 0, 0, o);
    chk("R1 disabled window quiet", {26'b0, o}, {26'b0, O_EXT});
    chk("R11 none set", {26'b0, o & ~O_EXT}, {26'b0, O_NONE});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_window();
    t_masks();
    t_wp();
    t_disable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule